// File: doc/BRIEF.md
# MDIO PHY Setup and Status Poller

This block is the management master for a bank of external Ethernet PHYs, eight by default. It produces the MDC clock and drives MDIO through a tri-state enable. Read data from the PHYs comes back on a separate input. Right after reset it sets up each PHY in turn, from the lowest address to the highest. For each PHY it first writes the advertisement register, offering every 10/100 ability plus the pause ability when the flow-control strap is high. It then writes the control register to restart auto-negotiation.

Once all PHYs are set up, the block polls without end. For each PHY it reads the status register and then the link-partner ability register. It turns those two words into four per-port outputs: link, speed, duplex and pause. The switch fabric reads these outputs directly.

Top module: `mdio_poller`

## Requirements
- R1: Every frame is PRE_LEN (default 32) ones, then start bits 01, then an opcode (01 = write, 10 = read), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround and 16 data bits. All fields are sent MSB first.
- R2: On a write, the master drives the turnaround as 1 then 0 and then drives the data. On a read, mdio_oe_o is low from the first turnaround bit to the end of the frame, and each data bit is taken from mdio_i at an MDC rising edge.
- R3: MDC has a period of CLK_DIV system clocks (even, at least 4), with half the period high and half low. mdio_o and mdio_oe_o change only right after an MDC falling edge.
- R4: Setup runs for port i = 0..NUM_PHY-1 in increasing order, at PHY address PHY_BASE+i (default 01000b..01111b). For each port it first writes register 4 with 0x01E1, with bit 10 set to fc_en_i. It then writes register 0 with 0x1200 (restart and enable auto-negotiation).
- R5: After the last setup write, init_done_o goes high and stays high until reset. From then on the block reads register 1 and then register 5 of each PHY, in increasing address order, and wraps around without end.
- R6: link_o[i] takes bit 2 of the last register 1 word read from PHY i.
- R7: When the link is up, speed100_o[i] and full_dup_o[i] take the best mode in register 5. Bit 8 gives 1/1, otherwise bit 7 gives 1/0, otherwise bit 6 gives 0/1, otherwise the result is 0/0.
- R8: pause_o[i] is high only when the link is up, fc_en_i is high and bit 10 of register 5 is set.
- R9: When a poll finds the link down, speed100_o[i] and full_dup_o[i] keep their previous values and pause_o[i] goes low.
- R10: In reset, all status outputs, mdc_o, mdio_oe_o and init_done_o are low. A port's outputs change only when the register 5 read of that port completes, so no status output changes during setup and only one port changes at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_en_i | input | 1 | Flow-control strap, held static; selects the pause advertisement |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable |
| init_done_o | output | 1 | PHY setup complete |
| link_o | output | NUM_PHY | Per-port link state |
| speed100_o | output | NUM_PHY | Per-port speed, 1 = 100 Mb/s |
| full_dup_o | output | NUM_PHY | Per-port duplex, 1 = full |
| pause_o | output | NUM_PHY | Per-port pause resolved |

## Verification
The assertions check, on every cycle, the timing rules of MDC and MDIO. Pin activity may only follow a falling MDC edge, and each MDC phase lasts at least two clocks. They also check that init_done_o never falls, that status stays quiet before setup ends, that at most one port changes per cycle, that speed and duplex never move while a link is down, and that pause never stands without link. Other behaviour is visible only in the bench's scenarios, where a modelled PHY decodes each frame: the exact frame fields, the order of PHY addresses and registers, the advertisement value under both strap settings, the turnaround release, and the priority that resolves each partner ability word.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;

  localparam logic [15:0] AN_RESTART = 16'h1200;
  localparam logic [15:0] ADV_BASE   = 16'h01E1;
  localparam int unsigned PAUSE_BIT  = 10;
  localparam int unsigned LINK_BIT   = 2;

  typedef enum logic {ST_ISSUE, ST_WAIT} seq_st_e;

  typedef struct packed {
    logic spd100;
    logic fdx;
  } mode_t;

  function automatic logic [15:0] adv_word(input logic fc);
    logic [15:0] w;
    w = ADV_BASE;
    w[PAUSE_BIT] = fc;
    return w;
  endfunction

  // highest common ability; local side advertises all four
  function automatic mode_t resolve_mode(input logic [15:0] lpa);
    mode_t m;
    if (lpa[8])      m = '{spd100: 1'b1, fdx: 1'b1};
    else if (lpa[7]) m = '{spd100: 1'b1, fdx: 1'b0};
    else if (lpa[6]) m = '{spd100: 1'b0, fdx: 1'b1};
    else             m = '{spd100: 1'b0, fdx: 1'b0};
    return m;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int unsigned CLK_DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);
  localparam int unsigned CW   = $clog2(CLK_DIV);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_stb_o = (cnt_q == CW'(HALF - 1));
  assign fall_stb_o = (cnt_q == CW'(CLK_DIV - 1));
  assign mdc_o      = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_stb_o ? '0 : cnt_q + 1'b1;
      if (rise_stb_o)      mdc_q <= 1'b1;
      else if (fall_stb_o) mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter #(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_stb_i,
  input  logic        fall_stb_i,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int unsigned FRAME_BITS = PRE_LEN + 32;
  localparam int unsigned BW         = $clog2(FRAME_BITS + 1);
  localparam int unsigned TA_POS     = PRE_LEN + 14;
  localparam int unsigned DATA_POS   = PRE_LEN + 16;

  logic [FRAME_BITS-1:0] sr_q, frame_w;
  logic [BW-1:0]         bcnt_q;
  logic                  wr_q, busy_q, done_q, mdio_q, oe_q;
  logic [15:0]           rdata_q;

  assign frame_w = {{PRE_LEN{1'b1}}, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, reg_i,
                    (wr_i ? 2'b10 : 2'b11), (wr_i ? wdata_i : 16'hFFFF)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
      wr_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mdio_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        sr_q   <= frame_w;
        wr_q   <= wr_i;
        busy_q <= 1'b1;
        bcnt_q <= '0;
      end else if (busy_q && fall_stb_i) begin
        if (bcnt_q == BW'(FRAME_BITS)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          mdio_q <= 1'b1;
          oe_q   <= 1'b0;
        end else begin
          mdio_q <= sr_q[FRAME_BITS-1];
          sr_q   <= sr_q << 1;
          oe_q   <= wr_q || (bcnt_q < BW'(TA_POS));
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  // bit in flight is bcnt_q-1; capture read data at the rising MDC edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (busy_q && rise_stb_i && !wr_q && (bcnt_q > BW'(DATA_POS)))
      rdata_q <= {rdata_q[14:0], mdio_i};
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int unsigned NUM_PHY  = 8,
  parameter logic [4:0]  PHY_BASE = 5'b01000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fc_en_i,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [15:0]        rdata_i,
  output logic               start_o,
  output logic               wr_o,
  output logic [4:0]         phy_o,
  output logic [4:0]         reg_o,
  output logic [15:0]        wdata_o,
  output logic               init_done_o,
  output logic [NUM_PHY-1:0] link_o,
  output logic [NUM_PHY-1:0] spd_o,
  output logic [NUM_PHY-1:0] dup_o,
  output logic [NUM_PHY-1:0] pause_o
);
  localparam int unsigned IW = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;

  seq_st_e           st_q;
  logic              poll_q, step_q, link_tmp_q;
  logic [IW-1:0]     idx_q;
  logic [NUM_PHY-1:0] link_q, spd_q, dup_q, pause_q;
  mode_t             mode_w;

  assign start_o = (st_q == ST_ISSUE) && !busy_i;
  assign wr_o    = !poll_q;
  assign phy_o   = PHY_BASE + 5'(idx_q);
  assign reg_o   = poll_q ? (step_q ? REG_LPA : REG_STAT) : (step_q ? REG_CTRL : REG_ADV);
  assign wdata_o = step_q ? AN_RESTART : adv_word(fc_en_i);
  assign mode_w  = resolve_mode(rdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_ISSUE;
      poll_q     <= 1'b0;
      step_q     <= 1'b0;
      idx_q      <= '0;
      link_tmp_q <= 1'b0;
      link_q     <= '0;
      spd_q      <= '0;
      dup_q      <= '0;
      pause_q    <= '0;
    end else begin
      case (st_q)
        ST_ISSUE: if (!busy_i) st_q <= ST_WAIT;
        ST_WAIT: if (done_i) begin
          st_q <= ST_ISSUE;
          if (poll_q && !step_q) link_tmp_q <= rdata_i[LINK_BIT];
          if (poll_q && step_q) begin
            link_q[idx_q]  <= link_tmp_q;
            pause_q[idx_q] <= link_tmp_q && fc_en_i && rdata_i[PAUSE_BIT];
            if (link_tmp_q) begin
              spd_q[idx_q] <= mode_w.spd100;
              dup_q[idx_q] <= mode_w.fdx;
            end
          end
          if (step_q) begin
            step_q <= 1'b0;
            if (idx_q == IW'(NUM_PHY - 1)) begin
              idx_q  <= '0;
              poll_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            step_q <= 1'b1;
          end
        end
        default: st_q <= ST_ISSUE;
      endcase
    end
  end

  assign init_done_o = poll_q;
  assign link_o      = link_q;
  assign spd_o       = spd_q;
  assign dup_o       = dup_q;
  assign pause_o     = pause_q;
endmodule

// File: rtl/mdio_poller.sv
`timescale 1ns/1ps
module mdio_poller #(
  parameter int unsigned NUM_PHY  = 8,
  parameter logic [4:0]  PHY_BASE = 5'b01000,
  parameter int unsigned CLK_DIV  = 20,
  parameter int unsigned PRE_LEN  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fc_en_i,
  input  logic               mdio_i,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic               init_done_o,
  output logic [NUM_PHY-1:0] link_o,
  output logic [NUM_PHY-1:0] speed100_o,
  output logic [NUM_PHY-1:0] full_dup_o,
  output logic [NUM_PHY-1:0] pause_o
);
  logic        rise_stb, fall_stb;
  logic        start, wr, busy, done;
  logic [4:0]  phy_addr, reg_addr;
  logic [15:0] wdata, rdata;

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mdc_o      (mdc_o),
    .rise_stb_o (rise_stb),
    .fall_stb_o (fall_stb)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_stb_i (rise_stb),
    .fall_stb_i (fall_stb),
    .start_i    (start),
    .wr_i       (wr),
    .phy_i      (phy_addr),
    .reg_i      (reg_addr),
    .wdata_i    (wdata),
    .busy_o     (busy),
    .done_o     (done),
    .rdata_o    (rdata),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  mdio_seq #(.NUM_PHY(NUM_PHY), .PHY_BASE(PHY_BASE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fc_en_i     (fc_en_i),
    .busy_i      (busy),
    .done_i      (done),
    .rdata_i     (rdata),
    .start_o     (start),
    .wr_o        (wr),
    .phy_o       (phy_addr),
    .reg_o       (reg_addr),
    .wdata_o     (wdata),
    .init_done_o (init_done_o),
    .link_o      (link_o),
    .spd_o       (speed100_o),
    .dup_o       (full_dup_o),
    .pause_o     (pause_o)
  );
endmodule

// File: rtl/mdio_poller_chk.sv
`timescale 1ns/1ps
module mdio_poller_chk #(
  parameter int unsigned NUM_PHY = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mdc_o,
  input logic               mdio_o,
  input logic               mdio_oe_o,
  input logic               init_done_o,
  input logic [NUM_PHY-1:0] link_o,
  input logic [NUM_PHY-1:0] speed100_o,
  input logic [NUM_PHY-1:0] full_dup_o,
  input logic [NUM_PHY-1:0] pause_o
);
  a_r3_mdio_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> $fell(mdc_o));
  a_r3_oe_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_oe_o) |-> $fell(mdc_o));
  a_r3_mdc_high_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |=> mdc_o);
  a_r3_mdc_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |=> !mdc_o);
  a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r10_quiet_in_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o |-> (link_o == '0 && pause_o == '0 && speed100_o == '0 && full_dup_o == '0));
  a_r10_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones((link_o ^ $past(link_o)) | (speed100_o ^ $past(speed100_o)) |
               (full_dup_o ^ $past(full_dup_o)) | (pause_o ^ $past(pause_o))) <= 1);
  a_r9_speed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((speed100_o ^ $past(speed100_o)) & ~link_o) == '0);
  a_r9_dup_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((full_dup_o ^ $past(full_dup_o)) & ~link_o) == '0);
  a_r8_pause_needs_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o & ~link_o) == '0);
endmodule

bind mdio_poller mdio_poller_chk #(.NUM_PHY(NUM_PHY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o),
  .init_done_o (init_done_o),
  .link_o      (link_o),
  .speed100_o  (speed100_o),
  .full_dup_o  (full_dup_o),
  .pause_o     (pause_o)
);

// File: tb/mdio_poller_tb.sv
`timescale 1ns/1ps
module mdio_poller_tb;
  localparam int CLK_PERIOD = 20;
  localparam int TB_DIV     = 8;
  localparam int NP         = 8;
  localparam int ROUNDS     = 6;

  logic clk = 1'b0, rst_n = 1'b0, fc_en = 1'b1, phy_drv = 1'b1;
  logic mdc, mdio_o, mdio_oe, init_done;
  logic [NP-1:0] link, spd, dup, pau;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_poller #(.NUM_PHY(NP), .CLK_DIV(TB_DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fc_en_i(fc_en), .mdio_i(phy_drv),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .init_done_o(init_done),
    .link_o(link), .speed100_o(spd), .full_dup_o(dup), .pause_o(pau));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] bmsr [NP];
  logic [15:0] lpa  [NP];
  logic [NP-1:0] e_link, e_spd, e_dup, e_pau;

  int          f_pre;
  logic [1:0]  f_op;
  logic [4:0]  f_phy, f_reg;
  logic [15:0] f_data, f_rd;
  bit          f_start_ok, f_ta_ok;
  time         t_rise0, t_fall, t_rise1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_adv(input logic fc);
    return fc ? 16'h05E1 : 16'h01E1;
  endfunction

  // bench model of PHY side: decodes one frame, answers reads
  task automatic get_frame();
    int ones = 0;
    logic [12:0] hdr = '0;
    bit rd;
    f_ta_ok = 1; f_data = '0; f_rd = 16'hFFFF; f_start_ok = 1;
    forever begin
      @(posedge mdc); #2;
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o) break;
      else ones = 0;
    end
    f_pre = ones;
    rd = 0;
    for (int p = 33; p < 64; p++) begin
      @(posedge mdc); #2;
      if (p <= 45) begin
        if (!mdio_oe) f_start_ok = 0;
        hdr = {hdr[11:0], mdio_o};
      end
      if (p == 45) begin
        if (!hdr[12]) f_start_ok = 0;
        f_op = hdr[11:10]; f_phy = hdr[9:5]; f_reg = hdr[4:0];
        rd = (f_op == 2'b10);
        if (rd && f_phy >= 5'd8 && f_phy < 5'd16)
          f_rd = (f_reg == 5'd1) ? bmsr[f_phy-8] : (f_reg == 5'd5) ? lpa[f_phy-8] : 16'h0;
      end
      if (p >= 46) begin
        if (rd) begin
          if (mdio_oe) f_ta_ok = 0;
        end else begin
          if (!mdio_oe) f_ta_ok = 0;
          if (p == 46 && !mdio_o) f_ta_ok = 0;
          if (p == 47 && mdio_o) f_ta_ok = 0;
        end
      end
      if (p >= 48) f_data = {f_data[14:0], rd ? phy_drv : mdio_o};
      if (rd) begin
        if (p == 46) phy_drv = 1'b0;
        else if (p >= 47 && p <= 62) phy_drv = f_rd[62-p];
        else if (p == 63) phy_drv = 1'b1;
      end
    end
  endtask

  task automatic settle();
    @(negedge mdc);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_frame(input bit wr, input int port, input logic [4:0] rg, input logic [15:0] d, input string tag);
    chk(f_pre == 32, "R1 preamble length", f_pre, 32);
    chk(f_start_ok, "R1 start bits", f_start_ok, 1);
    chk(f_op == (wr ? 2'b01 : 2'b10), {tag, " opcode"}, f_op, wr ? 1 : 2);
    chk(f_phy == 5'(8 + port), {tag, " PHY address order"}, f_phy, 8 + port);
    chk(f_reg == rg, {tag, " register"}, f_reg, rg);
    chk(f_ta_ok, "R2 turnaround", f_ta_ok, 1);
    if (wr) chk(f_data == d, {tag, " write data"}, f_data, d);
    else    chk(f_data == f_rd, "R2 read data path", f_data, f_rd);
  endtask

  task automatic chk_status(input string tag);
    chk(link == e_link, {tag, " R6 link"}, link, e_link);
    chk(spd == e_spd, {tag, " R7 speed"}, spd, e_spd);
    chk(dup == e_dup, {tag, " R7 duplex"}, dup, e_dup);
    chk(pau == e_pau, {tag, " R8 pause"}, pau, e_pau);
  endtask

  task automatic do_init();
    for (int k = 0; k < NP; k++) begin
      get_frame(); chk_frame(1, k, 5'd4, exp_adv(fc_en), "R4 adv");
      get_frame(); chk_frame(1, k, 5'd0, 16'h1200, "R4 restart");
    end
    settle();
    chk(init_done == 1'b1, "R5 init_done after setup", init_done, 1);
    chk(link == '0 && pau == '0, "R10 no status in setup", {link, pau}, 0);
  endtask

  task automatic do_round();
    logic lk;
    for (int k = 0; k < NP; k++) begin
      get_frame(); chk_frame(0, k, 5'd1, 0, "R5 poll stat");
      lk = f_rd[2];
      settle();
      chk_status("R10 unchanged after reg1");
      get_frame(); chk_frame(0, k, 5'd5, 0, "R5 poll lpa");
      e_link[k] = lk;
      e_pau[k]  = lk && fc_en && f_rd[10];
      if (lk) begin
        if (f_rd[8])      begin e_spd[k] = 1; e_dup[k] = 1; end
        else if (f_rd[7]) begin e_spd[k] = 1; e_dup[k] = 0; end
        else if (f_rd[6]) begin e_spd[k] = 0; e_dup[k] = 1; end
        else              begin e_spd[k] = 0; e_dup[k] = 0; end
      end
      settle();
      chk_status(lk ? "port up" : "R9 port down hold");
    end
  endtask

  // MDC period / duty measurement
  initial begin
    wait (rst_n);
    @(posedge mdc); t_rise0 = $time;
    @(negedge mdc); t_fall = $time;
    @(posedge mdc); t_rise1 = $time;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // directed first round
    bmsr[0] = 16'h0000; lpa[0] = 16'h05E1;
    bmsr[1] = 16'h0004; lpa[1] = 16'h0501;
    bmsr[2] = 16'h0004; lpa[2] = 16'h0081;
    bmsr[3] = 16'h0004; lpa[3] = 16'h0041;
    bmsr[4] = 16'h0004; lpa[4] = 16'h0021;
    bmsr[5] = 16'h0004; lpa[5] = 16'h0001;
    bmsr[6] = 16'hFFFF; lpa[6] = 16'hFFFF;
    bmsr[7] = 16'h0004; lpa[7] = 16'h0400;
    e_link = '0; e_spd = '0; e_dup = '0; e_pau = '0;
    repeat (5) @(negedge clk);
    chk(link == '0 && spd == '0 && dup == '0 && pau == '0, "R10 reset status", {link, spd, dup, pau}, 0);
    chk(!mdc && !mdio_oe && !init_done, "R10 reset pins", {mdc, mdio_oe, init_done}, 0);
    rst_n = 1'b1;
    do_init();
    chk(t_rise1 - t_rise0 == TB_DIV * CLK_PERIOD, "R3 MDC period", 32'(t_rise1 - t_rise0), TB_DIV * CLK_PERIOD);
    chk(t_fall - t_rise0 == TB_DIV * CLK_PERIOD / 2, "R3 MDC high time", 32'(t_fall - t_rise0), TB_DIV * CLK_PERIOD / 2);
    for (int r = 0; r < ROUNDS; r++) begin
      if (r == 1) begin
        bmsr[1] = 16'h0000; lpa[1] = 16'h0021; // R9: link drops, ability ignored
        bmsr[0] = 16'h0004; lpa[0] = 16'h0000;
      end else if (r >= 2) begin
        for (int k = 0; k < NP; k++) begin
          bmsr[k] = 16'($urandom());
          lpa[k]  = 16'($urandom());
        end
      end
      do_round();
    end
    // second run with the strap low
    rst_n = 1'b0; fc_en = 1'b0; phy_drv = 1'b1;
    e_link = '0; e_spd = '0; e_dup = '0; e_pau = '0;
    repeat (4) @(negedge clk);
    chk(init_done == 1'b0 && link == '0, "R10 reset again", {init_done, link}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < NP; k++) begin bmsr[k] = 16'h0004; lpa[k] = 16'h05E1; end
    do_init();
    do_round();
    chk(pau == '0, "R8 strap low gives no pause", pau, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R5 poll loop stalled actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule